// File: doc/BRIEF.md
# Three-Source Interrupt Controller for a Small CPU Core

This block collects three interrupt causes for a small CPU core and turns them into one interrupt request. The first cause is an external pin whose active edge software selects. The second is a one-cycle overflow pulse from an 8-bit timer. The third is any change on a four-bit slice of an input port, which covers the upper half of an 8-bit port. Each cause has a sticky flag and its own enable. A global enable sits over all three. Hardware only ever sets a flag. Software clears a flag by writing a 0 to it.

The core sees two outputs. `irq_req` makes the core branch to its interrupt vector, and it needs the global enable. `wake` ends sleep. It depends only on the individual enables, so a sleeping core can be woken even when vectoring is off. The core's acknowledge strobe clears the global enable, which blocks nesting. Its return strobe sets the global enable again.

Software reaches a control register (address 0) and an option register (address 1) over a simple register bus. Writes are synchronous and reads are combinational. The pin and the port inputs each pass through two synchronizing flops before the edge and change detectors.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the control register reads 8'h00 and the option register reads 8'hFF, and `irq_req` and `wake` are low.
- R2: When option bit 6 is 1, a low-to-high transition on `ext_pin` sets control bit 1. When option bit 6 is 0, a high-to-low transition sets it. The opposite transition leaves the flag unchanged.
- R3: A one-cycle high on `tmr_ovf` sets control bit 2.
- R4: Any difference between the synchronized `port_in` and its value in the previous cycle sets control bit 0. A value equal to the previous one does not set it.
- R5: Flags stay set until software writes 0 to them. If a hardware set and a software clear of the same flag land in the same cycle, the flag ends up set.
- R6: `irq_req` is high exactly when control bit 7 (global enable) is 1 and at least one flag has its enable set. The enable pairs are bit 5 with bit 2, bit 4 with bit 1, and bit 3 with bit 0.
- R7: `wake` is high exactly when `sleeping` is 1 and some flag has its enable set, whatever the value of control bit 7.
- R8: A cycle with `irq_ack` high clears control bit 7. A cycle with `irq_ret` high, and `irq_ack` low, sets control bit 7.
- R9: Control bit 6 always reads 0. `reg_addr` 0 selects the control register and `reg_addr` 1 selects the option register. The option register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| port_in | input | 4 | Upper port bits watched for change (asynchronous) |
| tmr_ovf | input | 1 | One-cycle timer rollover pulse |
| sleeping | input | 1 | Core is in sleep |
| irq_ack | input | 1 | Core takes the interrupt vector |
| irq_ret | input | 1 | Core returns from interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 option |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request during sleep |

## Verification
Some rules are checked by assertions on every cycle:
- a flag falls only after a control write;
- a timer pulse always leaves the timer flag set;
- acknowledge and return always move the global enable;
- detector events last a single cycle;
- `wake` stays low while the core is awake.

Other behaviour can only be shown by the bench's scenarios:
- which pin edge counts under each polarity;
- that an unchanged port value raises nothing;
- the set-over-clear collision;
- waking with the global enable off;
- the reset values.

// File: rtl/irq_pkg.sv
// Package: shared register widths, bit positions and reset values for the
// interrupt controller. Assumes an 8-bit register bus.
package irq_pkg;
    localparam int REG_W     = 8;
    localparam int NSRC      = 3;
    // control register bit positions
    localparam int B_GIE     = 7;
    localparam int B_RSV     = 6;
    localparam int B_EN_HI   = 5;
    localparam int B_EN_LO   = 3;
    localparam int B_FL_HI   = 2;
    localparam int B_FL_LO   = 0;
    // source index within the flag / enable fields
    localparam int S_PORT    = 0;
    localparam int S_PIN     = 1;
    localparam int S_TMR     = 2;
    // option register
    localparam int B_EDGE    = 6;
    localparam logic [REG_W-1:0] OPT_RST = 8'hFF;
    // register addresses
    localparam logic A_CTRL  = 1'b0;
    localparam logic A_OPT   = 1'b1;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchronizer for asynchronous inputs.
// Assumes STAGES >= 2. The reset value of every stage is 0.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int TOT = W * STAGES;

    logic [TOT-1:0] chain;

    // shift the input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[TOT-W-1:0], d};
    end

    assign q = chain[TOT-1 -: W];
endmodule

// File: rtl/irq_detect.sv
// Edge detector for the synchronized pin, with software-selected polarity,
// and a change detector for the synchronized port slice.
// Assumes both inputs are already synchronous to clk.
module irq_detect #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic              rise_sel,
    output logic              pin_evt,
    output logic              port_evt
);
    logic              pin_prev;
    logic [PORT_W-1:0] port_last;

    // remember last cycle's pin and port values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev  <= 1'b0;
            port_last <= '0;
        end else begin
            pin_prev  <= pin_s;
            port_last <= port_s;
        end
    end

    // pick the active edge; flag any difference on the port
    always_comb begin
        pin_evt  = rise_sel ? (pin_s & ~pin_prev) : (~pin_s & pin_prev);
        port_evt = |(port_s ^ port_last);
    end

    // R2: an edge event lasts exactly one cycle
    a_r2_pin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt && $stable(rise_sel) |=> !pin_evt);

    // R4: a port event needs the synchronized port to have moved
    a_r4_port_moved: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && port_evt |-> !$stable(port_s));
endmodule

// File: rtl/irq_regs.sv
// Control and option registers.
// Hardware sets the sticky flags. Software writes set or clear them, and a
// hardware set wins over a same-cycle clear. The core's acknowledge and
// return strobes move the global enable, with acknowledge taking priority.
module irq_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]  hw_set,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] opt
);
    logic            gie_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] fl_q;
    logic [REG_W-1:0] opt_q;
    logic            wr_ctrl;
    logic            wr_opt;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_opt  = reg_wr && (reg_addr == A_OPT);

    // global enable: acknowledge, then return, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (irq_ack)  gie_q <= 1'b0;
        else if (irq_ret)  gie_q <= 1'b1;
        else if (wr_ctrl)  gie_q <= reg_wdata[B_GIE];
    end

    // individual enables and option register: software only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            opt_q <= OPT_RST;
        end else begin
            if (wr_ctrl) en_q  <= reg_wdata[B_EN_HI:B_EN_LO];
            if (wr_opt)  opt_q <= reg_wdata;
        end
    end

    // sticky flags: a hardware set overrides a software write
    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= hw_set | (wr_ctrl ? reg_wdata[B_FL_HI:B_FL_LO] : fl_q);
    end

    assign ctrl = {gie_q, 1'b0, en_q, fl_q};
    assign opt  = opt_q;

    // R5: a flag falls only after a control write
    for (genvar i = 0; i < NSRC; i++) begin : g_flag_chk
        a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fl_q[i]) |-> $past(wr_ctrl));
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> fl_q[i]);
    end

    // R8: acknowledge clears and return sets the global enable
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ctrl[B_GIE]);
    a_r8_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret && !irq_ack |=> ctrl[B_GIE]);
endmodule

// File: rtl/irq_ctrl.sv
// Top of the three-source interrupt controller.
// Synchronizes the pin and port inputs, detects events, holds the registers,
// and derives the interrupt request and the wake-up request.
// Assumes tmr_ovf, irq_ack and irq_ret are synchronous one-cycle strobes.
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int PORT_W    = 4,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              tmr_ovf,
    input  logic              sleeping,
    input  logic              irq_ack,
    input  logic              irq_ret,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_req,
    output logic              wake
);
    localparam int SW = PORT_W + 1;

    logic [SW-1:0]     sync_q;
    logic              pin_evt;
    logic              port_evt;
    logic [NSRC-1:0]   hw_set;
    logic [REG_W-1:0]  ctrl;
    logic [REG_W-1:0]  opt;
    logic              pending;

    irq_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_pin, port_in}),
        .q     (sync_q)
    );

    irq_detect #(.PORT_W(PORT_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (sync_q[SW-1]),
        .port_s   (sync_q[PORT_W-1:0]),
        .rise_sel (opt[B_EDGE]),
        .pin_evt  (pin_evt),
        .port_evt (port_evt)
    );

    // gather the hardware set strobes in flag order
    always_comb begin
        hw_set         = '0;
        hw_set[S_TMR]  = tmr_ovf;
        hw_set[S_PIN]  = pin_evt;
        hw_set[S_PORT] = port_evt;
    end

    irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hw_set    (hw_set),
        .irq_ack   (irq_ack),
        .irq_ret   (irq_ret),
        .ctrl      (ctrl),
        .opt       (opt)
    );

    // outputs: read mux, request gated by the global enable, wake-up ungated
    always_comb begin
        pending   = |(ctrl[B_EN_HI:B_EN_LO] & ctrl[B_FL_HI:B_FL_LO]);
        irq_req   = ctrl[B_GIE] & pending;
        wake      = sleeping & pending;
        reg_rdata = (reg_addr == A_OPT) ? opt : ctrl;
    end

    // R7: no wake-up while the core is running
    a_r7_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> !wake);

    // R6: a request always has the global enable behind it
    a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl[B_GIE]);

    // R6 and R7: while asleep, a request implies a wake-up
    a_r6_req_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && sleeping |-> wake);
endmodule

// File: tb/test_irq_ctrl.sv
// Self-checking bench: a table of operations with expected results,
// followed by directed checks for reset, option readback and the
// set-over-clear collision.
module test_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic [3:0] port_in = 4'h0;
    logic       tmr_ovf = 1'b0;
    logic       sleeping = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic       wake;

    int applied = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
        .tmr_ovf(tmr_ovf), .sleeping(sleeping), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .wake(wake)
    );

    // operation codes
    localparam logic [3:0] OP_WC = 4'd0, OP_WO = 4'd1, OP_TM = 4'd2,
                           OP_PN = 4'd3, OP_PT = 4'd4, OP_AK = 4'd5,
                           OP_RT = 4'd6;
    localparam int NV = 25;
    // fields: req[26:23] op[22:19] arg[18:11] sleep[10] ctrl[9:2] irq[1] wake[0]
    localparam logic [26:0] VEC [NV] = '{
        {4'd9, OP_WC, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}, // R9 plain write
        {4'd3, OP_TM, 8'h00, 1'b0, 8'h04, 1'b0, 1'b0}, // R3 flag without enable
        {4'd5, OP_WC, 8'h20, 1'b0, 8'h20, 1'b0, 1'b0}, // R5 software clear
        {4'd6, OP_TM, 8'h00, 1'b0, 8'h24, 1'b0, 1'b0}, // R6 no global enable
        {4'd7, OP_WC, 8'h24, 1'b1, 8'h24, 1'b0, 1'b1}, // R7 wake without GIE
        {4'd6, OP_WC, 8'hA4, 1'b0, 8'hA4, 1'b1, 1'b0}, // R6 request
        {4'd8, OP_AK, 8'h00, 1'b0, 8'h24, 1'b0, 1'b0}, // R8 ack clears GIE
        {4'd8, OP_RT, 8'h00, 1'b0, 8'hA4, 1'b1, 1'b0}, // R8 return sets GIE
        {4'd5, OP_WC, 8'h90, 1'b0, 8'h90, 1'b0, 1'b0}, // R5 clear
        {4'd2, OP_PN, 8'h01, 1'b0, 8'h92, 1'b1, 1'b0}, // R2 rising edge
        {4'd5, OP_WC, 8'h90, 1'b0, 8'h90, 1'b0, 1'b0}, // R5 clear
        {4'd2, OP_PN, 8'h00, 1'b0, 8'h90, 1'b0, 1'b0}, // R2 falling ignored
        {4'd9, OP_WO, 8'hBF, 1'b0, 8'h90, 1'b0, 1'b0}, // R9 option write
        {4'd2, OP_PN, 8'h01, 1'b0, 8'h90, 1'b0, 1'b0}, // R2 rising ignored
        {4'd2, OP_PN, 8'h00, 1'b0, 8'h92, 1'b1, 1'b0}, // R2 falling edge
        {4'd6, OP_WC, 8'h88, 1'b0, 8'h88, 1'b0, 1'b0}, // R6 only port enabled
        {4'd4, OP_PT, 8'h05, 1'b0, 8'h89, 1'b1, 1'b0}, // R4 change
        {4'd5, OP_WC, 8'h88, 1'b0, 8'h88, 1'b0, 1'b0}, // R5 clear
        {4'd4, OP_PT, 8'h05, 1'b0, 8'h88, 1'b0, 1'b0}, // R4 same value
        {4'd4, OP_PT, 8'h04, 1'b0, 8'h89, 1'b1, 1'b0}, // R4 one bit change
        {4'd9, OP_WC, 8'h40, 1'b0, 8'h00, 1'b0, 1'b0}, // R9 reserved bit
        {4'd7, OP_WC, 8'h10, 1'b1, 8'h10, 1'b0, 1'b0}, // R7 asleep, nothing pending
        {4'd2, OP_PN, 8'h01, 1'b1, 8'h10, 1'b0, 1'b0}, // R2 wrong edge in sleep
        {4'd7, OP_PN, 8'h00, 1'b1, 8'h12, 1'b0, 1'b1}, // R7 wake by pin
        {4'd7, OP_WC, 8'h12, 1'b0, 8'h12, 1'b0, 1'b0}  // R7 wake drops awake
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] op);
        @(negedge clk);
        if (op == OP_TM) tmr_ovf = 1'b1;
        if (op == OP_AK) irq_ack = 1'b1;
        if (op == OP_RT) irq_ret = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++; applied++;
        $display("FAIL watchdog (R1 to R9) actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_addr = 1'b0;
        check("R1 ctrl", {24'd0, reg_rdata}, 32'h00);
        check("R1 irq/wake", {30'd0, irq_req, wake}, 32'h0);
        reg_addr = 1'b1; #1;
        check("R1 option", {24'd0, reg_rdata}, 32'hFF);
        reg_addr = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [7:0] arg;
            op  = VEC[i][22:19];
            arg = VEC[i][18:11];
            @(negedge clk);
            sleeping = VEC[i][10];
            case (op)
                OP_WC: reg_write(1'b0, arg);
                OP_WO: reg_write(1'b1, arg);
                OP_PN: ext_pin = arg[0];
                OP_PT: port_in = arg[3:0];
                default: strobe(op);
            endcase
            settle();
            check($sformatf("R%0d vector %0d", VEC[i][26:23], i),
                  {22'd0, reg_rdata, irq_req, wake}, {22'd0, VEC[i][9:0]});
        end

        // R9 option readback
        reg_addr = 1'b1; #1;
        check("R9 option readback", {24'd0, reg_rdata}, 32'hBF);
        reg_addr = 1'b0;

        // R5 timer set and software clear in the same cycle: set wins
        @(negedge clk);
        tmr_ovf = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h20;
        @(negedge clk);
        tmr_ovf = 1'b0; reg_wr = 1'b0;
        check("R5 set wins", {24'd0, reg_rdata}, 32'h24);

        // R8 acknowledge wins over a same-cycle software GIE write
        @(negedge clk);
        irq_ack = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hA4;
        @(negedge clk);
        irq_ack = 1'b0; reg_wr = 1'b0;
        check("R8 ack priority", {24'd0, reg_rdata}, 32'h24);

        // R1 reset in mid-run
        reg_write(1'b1, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ctrl after reset", {24'd0, reg_rdata}, 32'h00);
        reg_addr = 1'b1; #1;
        check("R1 option after reset", {24'd0, reg_rdata}, 32'hFF);
        reg_addr = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule